// File: doc/BRIEF.md
# Self-Calibrating Serial Byte Receiver

This block receives asynchronous 8N1 serial data: one start bit, eight data bits sent least significant bit first, no parity, and one stop bit. No baud rate is configured. The block learns the bit period, in cycles of its own loosely trimmed clock, from the ASCII space character (0x20).

When 0x20 is sent least significant bit first, the line stays low for exactly six bit times: the start bit plus five zero bits. The first high bit follows. The block counts that low stretch and divides it by six, rounding to the nearest cycle.

Until the first calibration, nothing is output. The receiver only looks for a low stretch whose length fits that pattern. After calibration it samples each bit at its centre. Every correctly framed space it receives reloads the period, so slow drift of the local oscillator is followed.

A long low line is reported as a break. So is a run of back-to-back framing errors. Either condition gives a single-cycle pulse.

Top module: `abr_rx`

## Requirements
- R1: After reset, `valid_o`, `ferr_o`, `brk_o` and `data_o` are zero, and `bit_period_o` is 0, meaning not calibrated.
- R2: While not calibrated, no byte is output. A low stretch shorter than 6*MIN_BIT cycles or longer than 6*MAX_BIT cycles leaves `bit_period_o` at 0.
- R3: While not calibrated, the first low stretch of L cycles with 6*MIN_BIT <= L <= 6*MAX_BIT sets `bit_period_o` to floor((L+3)/6). The character it belongs to is not output. Once calibrated, `bit_period_o` stays within [MIN_BIT, MAX_BIT].
- R4: Once calibrated, each byte is captured as follows:
  - Each bit is sampled half a period after the start edge, then once per period, with bit 0 first.
  - A byte whose stop bit samples high raises `valid_o` for exactly one cycle.
  - On that cycle `data_o` holds the byte and `ferr_o` is 0.
- R5: A byte whose stop bit samples low is held until the line returns high. It is then output with `valid_o` for one cycle, `ferr_o` = 1 and the sampled data.
- R6: Each correctly framed 0x20 received while calibrated is output as a normal byte. It also reloads `bit_period_o` with floor((L+3)/6), where L is the length of the low stretch that began at its start edge. This is done only if L lies in the R3 range.
- R7: A line held low for BREAK_CYCLES consecutive cycles gives one single-cycle `brk_o` pulse per low stretch. A byte in progress during that stretch is dropped, and no `valid_o` is produced.
- R8: FERR_RUN framing-error bytes in a row give one single-cycle `brk_o` pulse. A byte received without a framing error restarts the run.
- R9: A low pulse shorter than half a bit period is a false start: no byte is output and the calibration is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idle high, asynchronous |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe for a received byte |
| ferr_o | output | 1 | Framing error of the byte being strobed |
| brk_o | output | 1 | One-cycle break indication |
| bit_period_o | output | BIT_W | Learned bit period in clock cycles, 0 before calibration |

## Verification
The input passes two synchronizer flops and one edge register. As a result:
- A good byte is strobed about half a bit period into its stop bit plus three cycles.
- A framing-error byte is strobed three to four cycles after the line returns high.
- A line break pulses three cycles after its BREAK_CYCLES-th low cycle.

The bench counts strobes and pulses on falling clock edges. It checks those counts, and the captured data and flags, only after each frame has been followed by at least three idle bit times. That window contains every due cycle and no other event. For drift tracking, the bit periods are chosen so that every centre sample computed from the old period still lands inside the correct bit of the new timing. This lets the recalibrating space itself be checked exactly.

// File: rtl/abr_pkg.sv
package abr_pkg;
  typedef enum logic [2:0] {
    ST_UNCAL,
    ST_SKIP,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HOLD
  } abr_state_e;

  localparam logic [7:0]  CAL_CHAR  = 8'h20;
  localparam int unsigned CAL_LOW_BITS = 6;   // start bit + five zero bits of the space
  localparam int unsigned CAL_TAIL_BITS = 3;  // bits after the low stretch up to the stop bit
endpackage

// File: rtl/abr_sync.sv
module abr_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic rx_o,
  output logic fall_o,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rxd_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rx_o   = sync_q;
  assign fall_o = prev_q & ~sync_q;
  assign rise_o = ~prev_q & sync_q;
endmodule

// File: rtl/abr_meter.sv
module abr_meter #(
  parameter int unsigned RUN_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             fall_i,
  input  logic             rise_i,
  output logic             run_end_o,
  output logic [RUN_W-1:0] run_len_o
);
  localparam logic [RUN_W-1:0] RUN_SAT = '1;

  logic [RUN_W-1:0] low_cnt_q;

  // counts low cycles of the synchronized line, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
    end else if (!rx_i) begin
      if (fall_i)                  low_cnt_q <= RUN_W'(1);
      else if (low_cnt_q != RUN_SAT) low_cnt_q <= low_cnt_q + RUN_W'(1);
    end
  end

  assign run_end_o = rise_i;
  assign run_len_o = low_cnt_q;
endmodule

// File: rtl/abr_brk.sv
module abr_brk #(
  parameter int unsigned BREAK_CYCLES = 20000,
  parameter int unsigned FERR_RUN     = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic ferr_evt_i,
  input  logic good_evt_i,
  output logic line_brk_o,
  output logic run_brk_o
);
  localparam int unsigned BRK_W = $clog2(BREAK_CYCLES + 1);
  localparam int unsigned FR_W  = $clog2(FERR_RUN + 1);
  localparam logic [BRK_W-1:0] BRK_LAST = BRK_W'(BREAK_CYCLES - 1);
  localparam logic [BRK_W-1:0] BRK_TOP  = BRK_W'(BREAK_CYCLES);
  localparam logic [FR_W-1:0]  RUN_LAST = FR_W'(FERR_RUN - 1);

  logic [BRK_W-1:0] low_cnt_q;
  logic [FR_W-1:0]  run_cnt_q;
  logic             line_brk_q, run_brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q  <= '0;
      line_brk_q <= 1'b0;
    end else begin
      line_brk_q <= !rx_i && (low_cnt_q == BRK_LAST);
      if (rx_i)                   low_cnt_q <= '0;
      else if (low_cnt_q != BRK_TOP) low_cnt_q <= low_cnt_q + BRK_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt_q <= '0;
      run_brk_q <= 1'b0;
    end else begin
      run_brk_q <= 1'b0;
      if (ferr_evt_i) begin
        if (run_cnt_q == RUN_LAST) begin
          run_cnt_q <= '0;
          run_brk_q <= 1'b1;
        end else begin
          run_cnt_q <= run_cnt_q + FR_W'(1);
        end
      end else if (good_evt_i) begin
        run_cnt_q <= '0;
      end
    end
  end

  assign line_brk_o = line_brk_q;
  assign run_brk_o  = run_brk_q;

  a_r7_brk_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_brk_q |=> !line_brk_q);
  a_r8_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt_q <= RUN_LAST);
  a_r8_run_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_brk_q |-> $past(ferr_evt_i));
endmodule

// File: rtl/abr_framer.sv
module abr_framer
  import abr_pkg::*;
#(
  parameter int unsigned MIN_BIT = 8,
  parameter int unsigned MAX_BIT = 4095,
  parameter int unsigned BIT_W   = 12,
  parameter int unsigned RUN_W   = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             fall_i,
  input  logic             run_end_i,
  input  logic [RUN_W-1:0] run_len_i,
  input  logic             line_brk_i,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             ferr_o,
  output logic [BIT_W-1:0] period_o
);
  localparam logic [RUN_W-1:0] RUN_LO = RUN_W'(CAL_LOW_BITS * MIN_BIT);
  localparam logic [RUN_W-1:0] RUN_HI = RUN_W'(CAL_LOW_BITS * MAX_BIT);

  function automatic logic fits(input logic [RUN_W-1:0] r);
    return (r >= RUN_LO) && (r <= RUN_HI);
  endfunction

  function automatic logic [BIT_W-1:0] to_period(input logic [RUN_W-1:0] r);
    return BIT_W'(({1'b0, r} + (RUN_W+1)'(CAL_LOW_BITS / 2)) / (RUN_W+1)'(CAL_LOW_BITS));
  endfunction

  abr_state_e       state_q;
  logic [RUN_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic [BIT_W-1:0] period_q;
  logic [RUN_W-1:0] first_run_q;
  logic             fr_pend_q;
  logic             valid_q, ferr_q;
  logic [7:0]       data_q;

  logic [BIT_W-1:0] p_new;
  logic [RUN_W-1:0] p_new_x, skip_m1, half_m1, per_m1;

  always_comb begin
    p_new   = to_period(run_len_i);
    p_new_x = RUN_W'(p_new);
    // wait out the rest of the calibrating space up to mid stop bit
    skip_m1 = RUN_W'(CAL_TAIL_BITS) * p_new_x + (p_new_x >> 1) - RUN_W'(1);
    half_m1 = RUN_W'(period_q >> 1) - RUN_W'(1);
    per_m1  = RUN_W'(period_q) - RUN_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_UNCAL;
      cnt_q       <= '0;
      bit_q       <= '0;
      sh_q        <= '0;
      period_q    <= '0;
      first_run_q <= '0;
      fr_pend_q   <= 1'b0;
      valid_q     <= 1'b0;
      ferr_q      <= 1'b0;
      data_q      <= '0;
    end else begin
      valid_q <= 1'b0;
      if (run_end_i && fr_pend_q) begin
        first_run_q <= run_len_i;
        fr_pend_q   <= 1'b0;
      end
      unique case (state_q)
        ST_UNCAL: begin
          if (run_end_i && fits(run_len_i)) begin
            period_q <= p_new;
            cnt_q    <= skip_m1;
            state_q  <= ST_SKIP;
          end
        end
        ST_SKIP: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - RUN_W'(1);
        end
        ST_IDLE: begin
          if (fall_i) begin
            cnt_q     <= half_m1;
            fr_pend_q <= 1'b1;
            state_q   <= ST_START;
          end
        end
        ST_START: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - RUN_W'(1);
          end else if (!rx_i) begin
            cnt_q   <= per_m1;
            bit_q   <= '0;
            state_q <= ST_DATA;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_DATA: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - RUN_W'(1);
          end else begin
            sh_q  <= {rx_i, sh_q[7:1]};
            cnt_q <= per_m1;
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - RUN_W'(1);
          end else if (rx_i) begin
            valid_q <= 1'b1;
            ferr_q  <= 1'b0;
            data_q  <= sh_q;
            state_q <= ST_IDLE;
            if (sh_q == CAL_CHAR && !fr_pend_q && fits(first_run_q))
              period_q <= to_period(first_run_q);
          end else begin
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (line_brk_i) begin
            state_q <= ST_IDLE;
          end else if (rx_i) begin
            valid_q <= 1'b1;
            ferr_q  <= 1'b1;
            data_q  <= sh_q;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_UNCAL;
      endcase
    end
  end

  assign valid_o  = valid_q;
  assign data_o   = data_q;
  assign ferr_o   = ferr_q;
  assign period_o = period_q;

  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  a_r3_period_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_UNCAL) |-> (period_q >= BIT_W'(MIN_BIT) && period_q <= BIT_W'(MAX_BIT)));
  a_r9_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && $past(state_q) == ST_START) |-> !$past(rx_i));
  a_r2_quiet_uncal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UNCAL) |=> !valid_q);
endmodule

// File: rtl/abr_rx.sv
module abr_rx #(
  parameter int unsigned MIN_BIT      = 8,
  parameter int unsigned MAX_BIT      = 4095,
  parameter int unsigned BREAK_CYCLES = 20000,
  parameter int unsigned FERR_RUN     = 100,
  localparam int unsigned BIT_W       = $clog2(MAX_BIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  output logic [7:0]       data_o,
  output logic             valid_o,
  output logic             ferr_o,
  output logic             brk_o,
  output logic [BIT_W-1:0] bit_period_o
);
  localparam int unsigned RUN_W = $clog2(abr_pkg::CAL_LOW_BITS * MAX_BIT + 2);

  logic             rx_s, fall_s, rise_s;
  logic             run_end;
  logic [RUN_W-1:0] run_len;
  logic             line_brk, run_brk;

  abr_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rxd_i (rxd_i),
    .rx_o  (rx_s),
    .fall_o(fall_s),
    .rise_o(rise_s)
  );

  abr_meter #(.RUN_W(RUN_W)) u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_i     (rx_s),
    .fall_i   (fall_s),
    .rise_i   (rise_s),
    .run_end_o(run_end),
    .run_len_o(run_len)
  );

  abr_framer #(
    .MIN_BIT(MIN_BIT),
    .MAX_BIT(MAX_BIT),
    .BIT_W  (BIT_W),
    .RUN_W  (RUN_W)
  ) u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_s),
    .fall_i    (fall_s),
    .run_end_i (run_end),
    .run_len_i (run_len),
    .line_brk_i(line_brk),
    .valid_o   (valid_o),
    .data_o    (data_o),
    .ferr_o    (ferr_o),
    .period_o  (bit_period_o)
  );

  abr_brk #(
    .BREAK_CYCLES(BREAK_CYCLES),
    .FERR_RUN    (FERR_RUN)
  ) u_brk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_s),
    .ferr_evt_i(valid_o & ferr_o),
    .good_evt_i(valid_o & ~ferr_o),
    .line_brk_o(line_brk),
    .run_brk_o (run_brk)
  );

  assign brk_o = line_brk | run_brk;
endmodule

// File: tb/abr_rx_bench.sv
`timescale 1ns/1ps
module abr_rx_bench;
  localparam int unsigned MIN_BIT = 8;
  localparam int unsigned MAX_BIT = 255;
  localparam int unsigned BRK_CYC = 2000;
  localparam int unsigned FRUN    = 3;
  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h7E, 8'h01};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] data;
  logic       valid, ferr, brk;
  logic [7:0] period;

  int n_chk = 0, n_fail = 0;
  int vcnt = 0, bcnt = 0;
  logic [7:0] last_data = '0;
  logic       last_ferr = 1'b0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  abr_rx #(
    .MIN_BIT(MIN_BIT), .MAX_BIT(MAX_BIT), .BREAK_CYCLES(BRK_CYC), .FERR_RUN(FRUN)
  ) u_abr_rx (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd),
    .data_o(data), .valid_o(valid), .ferr_o(ferr), .brk_o(brk), .bit_period_o(period)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        vcnt <= vcnt + 1;
        last_data <= data;
        last_ferr <= ferr;
      end
      if (brk) bcnt <= bcnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic send(input logic [7:0] b, input int p, input bit stop_ok);
    @(negedge clk);
    rxd = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (p) @(negedge clk);
    end
    rxd = stop_ok;
    repeat (p) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * p) @(negedge clk);
  endtask

  task automatic expect_byte(input string req, input int v0, input logic [7:0] d, input logic fe);
    check(req, vcnt - v0, 1);
    check(req, int'(last_data), int'(d));
    check(req, int'(last_ferr), int'(fe));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int v0, b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(valid), 0);
    check("R1 ferr", int'(ferr), 0);
    check("R1 brk", int'(brk), 0);
    check("R1 data", int'(data), 0);
    check("R1 period", int'(period), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 short runs and an over-long run leave it uncalibrated
    v0 = vcnt;
    send(8'h55, 20, 1'b1);
    check("R2 short runs period", int'(period), 0);
    send(8'h00, 200, 1'b1);
    check("R2 long run period", int'(period), 0);
    check("R2 no output", vcnt - v0, 0);

    // R3 first space calibrates, not output
    send(8'h20, 20, 1'b1);
    check("R3 period", int'(period), 20);
    check("R3 space not output", vcnt - v0, 0);

    // R4 vector table at period 20
    for (int k = 0; k < NVEC; k++) begin
      v0 = vcnt;
      send(VEC[k], 20, 1'b1);
      expect_byte("R4 table", v0, VEC[k], 1'b0);
    end

    // R5 stop bit low
    v0 = vcnt;
    send(8'h5A, 20, 1'b0);
    expect_byte("R5 framing", v0, 8'h5A, 1'b1);

    // R6 drift tracking 20 -> 21 -> 22
    v0 = vcnt;
    send(8'h20, 21, 1'b1);
    expect_byte("R6 space 21", v0, 8'h20, 1'b0);
    check("R6 period 21", int'(period), 21);
    v0 = vcnt;
    send(8'hC3, 21, 1'b1);
    expect_byte("R6 byte 21", v0, 8'hC3, 1'b0);
    v0 = vcnt;
    send(8'h20, 22, 1'b1);
    check("R6 period 22", int'(period), 22);
    v0 = vcnt;
    send(8'h96, 22, 1'b1);
    expect_byte("R6 byte 22", v0, 8'h96, 1'b0);

    // R9 glitch shorter than half a bit
    v0 = vcnt;
    b0 = bcnt;
    @(negedge clk);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    check("R9 glitch no byte", vcnt - v0, 0);
    check("R9 period kept", int'(period), 22);

    // R7 line break
    @(negedge clk);
    rxd = 1'b0;
    repeat (BRK_CYC + 500) @(negedge clk);
    rxd = 1'b1;
    repeat (100) @(negedge clk);
    check("R7 one break pulse", bcnt - b0, 1);
    check("R7 byte dropped", vcnt - v0, 0);
    v0 = vcnt;
    send(8'h3C, 22, 1'b1);
    expect_byte("R7 after break", v0, 8'h3C, 1'b0);

    // R8 framing-error run
    b0 = bcnt;
    v0 = vcnt;
    send(8'h81, 22, 1'b0);
    expect_byte("R8 first error", v0, 8'h81, 1'b1);
    send(8'h81, 22, 1'b0);
    send(8'h42, 22, 1'b1);
    send(8'h81, 22, 1'b0);
    send(8'h81, 22, 1'b0);
    check("R8 good byte restarts run", bcnt - b0, 0);
    send(8'h81, 22, 1'b0);
    check("R8 run break", bcnt - b0, 1);
    check("R8 all bytes out", vcnt - v0, 6);

    report();
  end
endmodule